// File: doc/BRIEF.md
# ALU Operand Bypass Select Unit

This block decides, for each of the two ALU operands of the instruction now in the execute stage of a five-stage in-order integer pipeline, where that operand should come from. The source is one of three places: the value read from the register file, the result held in the execute-to-memory pipeline register, or the result held in the memory-to-writeback pipeline register. A younger instruction can therefore use a result before that result is written back. The execute-to-memory path serves a consumer directly behind its producer. The memory-to-writeback path serves a consumer two instructions behind.

The unit compares the two source register numbers with the destination of each older in-flight instruction. A match counts only when that instruction writes the register file and its destination is not register zero. When both older instructions match the same source, the younger producer, the one in execute-to-memory, takes priority. The two operand selects are worked out separately. The outputs depend only on the current inputs: the unit holds no state and needs no clock or reset. The ALU input multiplexers, the pipeline registers and load-use stall detection sit outside this block.

Top module: `fwd_unit`

## Requirements
- R1: When no qualifying producer matches a source register, that operand's select is 2'b00, meaning the register-file value.
- R2: When the execute-to-memory producer has its write flag set, has a nonzero destination, and that destination equals the operand-A source, `sel_a` is 2'b10.
- R3: When the execute-to-memory producer has its write flag set, has a nonzero destination, and that destination equals the operand-B source, `sel_b` is 2'b10.
- R4: When the memory-to-writeback producer has its write flag set, has a nonzero destination that equals an operand's source, and the execute-to-memory producer does not qualify for that operand, the select is 2'b01.
- R5: A producer whose destination is register 0 never causes a forward, even when its write flag is set and the source is also 0.
- R6: A producer whose write flag is clear never causes a forward, whatever its destination.
- R7: When both producers qualify for the same operand, the select is 2'b10.
- R8: Each operand is decided on its own, so `sel_a` and `sel_b` may take different nonzero codes in the same cycle.
- R9: The code 2'b11 is never produced on either select.
- R10: The selects follow a change on any input within the same cycle, before the next clock edge, with no state kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a_idx | input | 5 | Operand-A source register number of the execute-stage instruction |
| src_b_idx | input | 5 | Operand-B source register number of the execute-stage instruction |
| exm_dst_idx | input | 5 | Destination register number held in the execute-to-memory register |
| exm_wr_en | input | 1 | Register-write flag held in the execute-to-memory register |
| mwb_dst_idx | input | 5 | Destination register number held in the memory-to-writeback register |
| mwb_wr_en | input | 1 | Register-write flag held in the memory-to-writeback register |
| sel_a | output | 2 | Operand-A source select: 00 register file, 10 execute-to-memory, 01 memory-to-writeback |
| sel_b | output | 2 | Operand-B source select, same encoding as sel_a |

## Verification
The unit holds no state, so any fault shows up at the select ports in the same cycle as the input pattern that triggers it. A broken comparison, a missing register-zero or write-flag qualifier, or inverted priority makes the ALU consume a stale or wrong value. At the ports this appears as a select differing from the expected code for exactly those patterns. The stimulus draws register numbers from a narrow range so that matches, double matches, and register-zero cases occur often. Directed patterns pin down each qualifier and the priority order.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int REG_IDX_W = 5;
  localparam int SEL_W     = 2;

  typedef enum logic [SEL_W-1:0] {
    SRC_REGFILE = 2'b00,
    SRC_MWB     = 2'b01,
    SRC_EXM     = 2'b10
  } fwd_src_e;
endpackage

// File: rtl/fwd_match.sv
// One producer against one consumer source: qualified equality test.
module fwd_match #(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] src_idx,
  input  logic [IDX_W-1:0] dst_idx,
  input  logic             wr_en,
  output logic             hit
);
  localparam logic [IDX_W-1:0] ZERO_IDX = '0;

  logic dst_live;
  logic idx_eq;

  always_comb begin
    dst_live = wr_en && (dst_idx != ZERO_IDX);
    idx_eq   = (dst_idx == src_idx);
    hit      = dst_live && idx_eq;
  end
endmodule

// File: rtl/fwd_prio.sv
// Picks the operand source from the two producer hits; younger producer wins.
module fwd_prio
  import fwd_pkg::*;
(
  input  logic     exm_hit,
  input  logic     mwb_hit,
  output fwd_src_e sel
);
  always_comb begin
    if (exm_hit)      sel = SRC_EXM;
    else if (mwb_hit) sel = SRC_MWB;
    else              sel = SRC_REGFILE;
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int IDX_W = REG_IDX_W
) (
  input  logic [IDX_W-1:0] src_a_idx,
  input  logic [IDX_W-1:0] src_b_idx,
  input  logic [IDX_W-1:0] exm_dst_idx,
  input  logic             exm_wr_en,
  input  logic [IDX_W-1:0] mwb_dst_idx,
  input  logic             mwb_wr_en,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b
);
  localparam int NUM_OPS = 2;

  logic [IDX_W-1:0] src_idx [NUM_OPS];
  logic             exm_hit [NUM_OPS];
  logic             mwb_hit [NUM_OPS];
  fwd_src_e         op_sel  [NUM_OPS];

  assign src_idx[0] = src_a_idx;
  assign src_idx[1] = src_b_idx;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    fwd_match #(.IDX_W(IDX_W)) u_exm (
      .src_idx (src_idx[g]),
      .dst_idx (exm_dst_idx),
      .wr_en   (exm_wr_en),
      .hit     (exm_hit[g])
    );
    fwd_match #(.IDX_W(IDX_W)) u_mwb (
      .src_idx (src_idx[g]),
      .dst_idx (mwb_dst_idx),
      .wr_en   (mwb_wr_en),
      .hit     (mwb_hit[g])
    );
    fwd_prio u_prio (
      .exm_hit (exm_hit[g]),
      .mwb_hit (mwb_hit[g]),
      .sel     (op_sel[g])
    );
  end

  assign sel_a = op_sel[0];
  assign sel_b = op_sel[1];

  always_comb begin
    if (!$isunknown({src_a_idx, src_b_idx, exm_dst_idx, exm_wr_en, mwb_dst_idx, mwb_wr_en})) begin
      AST_SEL_LEGAL: assert (sel_a != 2'b11 && sel_b != 2'b11); // R9
      AST_A_EXM_SRC: assert (sel_a != 2'b10 || (exm_wr_en && exm_dst_idx == src_a_idx)); // R2
      AST_B_EXM_SRC: assert (sel_b != 2'b10 || (exm_wr_en && exm_dst_idx == src_b_idx)); // R3
      AST_MWB_SRC: assert ((sel_a != 2'b01 || (mwb_wr_en && mwb_dst_idx == src_a_idx)) &&
                           (sel_b != 2'b01 || (mwb_wr_en && mwb_dst_idx == src_b_idx))); // R4
      AST_ZERO_NO_FWD: assert ((src_a_idx != '0 || sel_a == 2'b00) &&
                               (src_b_idx != '0 || sel_b == 2'b00)); // R5
      AST_NOWR_NO_FWD: assert (!(!exm_wr_en && !mwb_wr_en) || (sel_a == 2'b00 && sel_b == 2'b00)); // R6
    end
  end
endmodule

// File: tb/fwd_unit_tb_top.sv
module fwd_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 3000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [4:0] src_a, src_b, exm_dst, mwb_dst;
  logic       exm_wr, mwb_wr;
  logic [1:0] sel_a, sel_b;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  fwd_unit dut_i (
    .src_a_idx   (src_a),
    .src_b_idx   (src_b),
    .exm_dst_idx (exm_dst),
    .exm_wr_en   (exm_wr),
    .mwb_dst_idx (mwb_dst),
    .mwb_wr_en   (mwb_wr),
    .sel_a       (sel_a),
    .sel_b       (sel_b)
  );

  function automatic logic [1:0] exp_sel(input logic [4:0] s, input logic [4:0] ed, input logic ew,
                                         input logic [4:0] md, input logic mw);
    if (ew && ed != 5'd0 && ed == s) return 2'b10;
    if (mw && md != 5'd0 && md == s) return 2'b01;
    return 2'b00;
  endfunction

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b (sa=%0d sb=%0d ed=%0d ew=%b md=%0d mw=%b)",
               req, act, exp, src_a, src_b, exm_dst, exm_wr, mwb_dst, mwb_wr);
    end
  endtask

  // Drive after a rising edge, check halfway before the falling edge.
  task automatic apply(input logic [4:0] sa, input logic [4:0] sb, input logic [4:0] ed,
                       input logic ew, input logic [4:0] md, input logic mw,
                       input string req_a, input string req_b);
    @(posedge clk);
    #1;
    src_a = sa; src_b = sb; exm_dst = ed; exm_wr = ew; mwb_dst = md; mwb_wr = mw;
    #1;
    check(req_a, sel_a, exp_sel(sa, ed, ew, md, mw));
    check(req_b, sel_b, exp_sel(sb, ed, ew, md, mw));
  endtask

  initial begin
    src_a = '0; src_b = '0; exm_dst = '0; mwb_dst = '0; exm_wr = 1'b0; mwb_wr = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset idle a", sel_a, 2'b00);
    check("R1 reset idle b", sel_b, 2'b00);

    apply(5'd3, 5'd4, 5'd7, 1, 5'd9, 1, "R1 a", "R1 b");
    apply(5'd7, 5'd4, 5'd7, 1, 5'd9, 1, "R2 a", "R1 b");
    apply(5'd4, 5'd7, 5'd7, 1, 5'd9, 1, "R1 a", "R3 b");
    apply(5'd9, 5'd9, 5'd7, 1, 5'd9, 1, "R4 a", "R4 b");
    apply(5'd0, 5'd0, 5'd0, 1, 5'd0, 1, "R5 a", "R5 b");
    apply(5'd12, 5'd12, 5'd12, 0, 5'd12, 0, "R6 a", "R6 b");
    apply(5'd12, 5'd12, 5'd12, 0, 5'd12, 1, "R6 exm off a", "R6 exm off b");
    apply(5'd20, 5'd20, 5'd20, 1, 5'd20, 1, "R7 a", "R7 b");
    apply(5'd0, 5'd20, 5'd0, 1, 5'd20, 1, "R5 mixed a", "R4 mixed b");
    apply(5'd5, 5'd6, 5'd5, 1, 5'd6, 1, "R8 a exm", "R8 b mwb");
    apply(5'd6, 5'd5, 5'd5, 1, 5'd6, 1, "R8 a mwb", "R8 b exm");
    apply(5'd31, 5'd31, 5'd31, 1, 5'd1, 1, "R2 top idx", "R3 top idx");

    // R10: change only one input within a cycle and observe at once
    apply(5'd8, 5'd8, 5'd8, 1, 5'd2, 0, "R10 a before", "R10 b before");
    #1 exm_wr = 1'b0;
    #1;
    check("R10 a after", sel_a, 2'b00);
    check("R10 b after", sel_b, 2'b00);

    void'($urandom(32'd2718));
    for (int i = 0; i < N_RANDOM; i++) begin
      logic [4:0] sa, sb, ed, md;
      sa = 5'($urandom_range(0, 3));
      sb = 5'($urandom_range(0, 3));
      ed = 5'($urandom_range(0, 3));
      md = 5'($urandom_range(0, 3));
      if ($urandom_range(0, 7) == 0) sa = 5'($urandom);
      if ($urandom_range(0, 7) == 0) md = 5'($urandom);
      apply(sa, sb, ed, 1'($urandom), md, 1'($urandom), "R1-R8 rand a", "R1-R8 rand b");
      if (sel_a == 2'b11 || sel_b == 2'b11) begin
        n_fail++;
        $display("FAIL R9: actual %b/%b expected no 11", sel_a, sel_b);
      end
      n_checks++;
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule